// File: doc/BRIEF.md
# NOR Flash Word Programming Controller

This block sits on the host side of an asynchronous parallel NOR flash bus and writes a contiguous run of words into the device. A request gives a starting word address and a word count. For each word, the block fetches the value from a data source port and sends the three-write unlock-and-program preamble. It then writes the word itself and reads the device back until the device reports that the word is finished or that it failed.

Completion is judged by data polling. While the device is busy it returns the complement of the programmed value on bit 7. When bit 7 matches, the word is accepted. Bit 5 is the device's time-limit flag. If bit 5 is set while bit 7 still disagrees, the block makes exactly one more read. This is needed because the device may finish in the same instant it raises the flag. On a failure, the block returns the device to read mode and then reports the failing address. Bus write and read strobes are timed in whole clock cycles that are set by parameters.

Top module: `nor_prog_ctrl`

## Requirements
- R1: While reset is held, chip enable, write enable and output enable are all high (inactive), and the done and failed pulses are low.
- R2: For each word the bus carries four writes in this order: address 0x555 with data 0xAA, address 0x2AA with data 0x55, address 0x555 with data 0xA0, then the target word address with the value present on `src_data` while `src_idx` equals the word's offset from the base.
- R3: Every write keeps write enable low for exactly WR_PULSE clocks. Chip enable is low throughout, and address and data do not change while write enable is low.
- R4: Every read keeps output enable low for exactly RD_WAIT clocks with chip enable low, and write enable and output enable are never low together.
- R5: After the program write, the target address is read repeatedly. A read whose bit 7 equals bit 7 of the programmed value accepts the word. A mismatching read with bit 5 clear leads to another read.
- R6: A read whose bit 7 mismatches and whose bit 5 is 1 is followed by exactly one re-read. If bit 7 matches on that re-read, the word is accepted and programming continues.
- R7: If bit 7 mismatches on the re-read, the block writes data 0xF0 to the failing word address. It then raises `failed` for one clock with `fail_addr` set to that address and programs no further words.
- R8: Words are programmed at base, base+1, …, base+count-1. After the last word is accepted, `done` is high for exactly one clock.
- R9: A request with a count of zero produces `done` without any bus cycle.
- R10: A `start` pulse that arrives while a request is in progress is ignored. The bus traffic is that of the original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled only when idle |
| base_addr | input | AW | First word address of the run |
| word_count | input | AW | Number of words to program |
| src_idx | output | AW | Offset of the word whose value is wanted |
| src_data | input | DW | Value for the word at `src_idx` |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| done | output | 1 | One-clock pulse: run finished correctly |
| failed | output | 1 | One-clock pulse: a word failed |
| fail_addr | output | AW | Address of the failed word, valid with `failed` |

## Verification
Two verdicts can fall on the same device read: the word finishing, and the time-limit flag being raised. The bench's device model provokes this by returning bit 5 set with bit 7 still wrong on one read, and returning the true data on the next. The re-read must then accept the word and the run must continue without an abort write. A second model mode keeps bit 7 wrong on the re-read. In that case the scoreboard expects the 0xF0 write at the failing address, then `failed` with `fail_addr`, and the per-run total of reads must match the exact count the requirements imply.

// File: rtl/nfl_pkg.sv
// Shared types and command constants for the NOR flash programming controller.
// Assumes a word-wide (16-bit) device with command addresses in word units.
package nfl_pkg;

    // Bus cycle engine states
    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_WSETUP,
        BUS_WPULSE,
        BUS_WHOLD,
        BUS_RACCESS
    } bus_state_e;

    // Outcome of one polling read
    typedef enum logic [1:0] {
        V_PASS,
        V_RETRY,
        V_RECHECK,
        V_FAIL
    } verdict_e;

    // Programming sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_CMD_W,
        S_RD,
        S_RD_W,
        S_EVAL,
        S_ABORT,
        S_ABORT_W,
        S_FIN_OK,
        S_FIN_BAD
    } seq_state_e;

    localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
    localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
    localparam logic [7:0]  CMD_UNLOCK1   = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK2   = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0]  CMD_READRST   = 8'hF0;

    // Bit positions the device uses for status during programming
    localparam int POLL_BIT = 7;
    localparam int TMO_BIT  = 5;

endpackage

// File: rtl/nfl_bus_engine.sv
// Bus cycle engine: runs one asynchronous flash write or read at a time.
// Write: 1 setup clock (CE low), WR_PULSE clocks with WE low, 1 hold clock.
// Read: RD_WAIT clocks with CE and OE low; status bits sampled on the last.
// Assumes wr_go and rd_go are single-clock pulses given only while idle.
module nfl_bus_engine
    import nfl_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int WR_PULSE = 3,
    parameter int RD_WAIT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic [AW-1:0] cyc_addr,
    input  logic [DW-1:0] cyc_wdata,
    output logic          cyc_done,
    output logic          poll_b7,
    output logic          poll_b5,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int MAXW = (WR_PULSE > RD_WAIT) ? WR_PULSE : RD_WAIT;
    localparam int CW   = $clog2(MAXW + 1);

    bus_state_e    st;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Cycle state machine, strobe counter and status capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= BUS_IDLE;
            cnt      <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            cyc_done <= 1'b0;
            poll_b7  <= 1'b0;
            poll_b5  <= 1'b0;
        end else begin
            cyc_done <= 1'b0;
            case (st)
                BUS_IDLE: begin
                    if (wr_go) begin
                        addr_q <= cyc_addr;
                        data_q <= cyc_wdata;
                        st     <= BUS_WSETUP;
                    end else if (rd_go) begin
                        addr_q <= cyc_addr;
                        cnt    <= CW'(RD_WAIT - 1);
                        st     <= BUS_RACCESS;
                    end
                end
                BUS_WSETUP: begin
                    cnt <= CW'(WR_PULSE - 1);
                    st  <= BUS_WPULSE;
                end
                BUS_WPULSE: begin
                    if (cnt == '0) st <= BUS_WHOLD;
                    else           cnt <= cnt - 1'b1;
                end
                BUS_WHOLD: begin
                    st       <= BUS_IDLE;
                    cyc_done <= 1'b1;
                end
                BUS_RACCESS: begin
                    if (cnt == '0) begin
                        poll_b7  <= fl_rdata[POLL_BIT];
                        poll_b5  <= fl_rdata[TMO_BIT];
                        st       <= BUS_IDLE;
                        cyc_done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= BUS_IDLE;
            endcase
        end
    end

    // Strobes decoded from the registered state
    always_comb begin
        fl_addr  = addr_q;
        fl_wdata = data_q;
        fl_ce_n  = (st == BUS_IDLE);
        fl_we_n  = (st != BUS_WPULSE);
        fl_oe_n  = (st != BUS_RACCESS);
    end

    // R4
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    // R3
    ce_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

    // R3
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

endmodule

// File: rtl/nfl_poll_judge.sv
// Poll judge: turns one status read into a verdict by the data-polling rule.
// First look: bit 7 equal -> pass; unequal with bit 5 set -> recheck; else retry.
// Second look (after the time-limit flag): bit 7 equal -> pass, else fail.
module nfl_poll_judge
    import nfl_pkg::*;
(
    input  logic     rd_b7,
    input  logic     rd_b5,
    input  logic     exp_b7,
    input  logic     second_look,
    output verdict_e verdict
);
    // Combinational verdict
    always_comb begin
        if (rd_b7 == exp_b7) verdict = V_PASS;
        else if (second_look) verdict = V_FAIL;
        else if (rd_b5)       verdict = V_RECHECK;
        else                  verdict = V_RETRY;
    end
endmodule

// File: rtl/nfl_prog_seq.sv
// Programming sequencer: walks the word run, issues the unlock/program
// writes, drives polling reads and acts on the judge's verdict.
// Assumes src_data is valid combinationally for the presented src_idx.
module nfl_prog_seq
    import nfl_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] word_count,
    output logic [AW-1:0] src_idx,
    input  logic [DW-1:0] src_data,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_wdata,
    input  logic          cyc_done,
    input  verdict_e      verdict,
    output logic          second_look,
    output logic          exp_b7,
    output logic          done,
    output logic          failed,
    output logic [AW-1:0] fail_addr
);
    localparam int PAD = DW - 8;

    seq_state_e    st;
    logic [1:0]    step;
    logic [AW-1:0] base_q;
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] remain;
    logic [DW-1:0] prog_q;

    assign src_idx = cur_addr - base_q;
    assign exp_b7  = prog_q[POLL_BIT];

    // Main sequencing of commands, polling and run bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            step        <= '0;
            base_q      <= '0;
            cnt_q       <= '0;
            cur_addr    <= '0;
            remain      <= '0;
            prog_q      <= '0;
            second_look <= 1'b0;
            wr_go       <= 1'b0;
            rd_go       <= 1'b0;
            cyc_addr    <= '0;
            cyc_wdata   <= '0;
            done        <= 1'b0;
            failed      <= 1'b0;
            fail_addr   <= '0;
        end else begin
            wr_go  <= 1'b0;
            rd_go  <= 1'b0;
            done   <= 1'b0;
            failed <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        base_q   <= base_addr;
                        cnt_q    <= word_count;
                        cur_addr <= base_addr;
                        remain   <= word_count;
                        step     <= '0;
                        st       <= (word_count == '0) ? S_FIN_OK : S_CMD;
                    end
                end
                S_CMD: begin
                    wr_go <= 1'b1;
                    case (step)
                        2'd0: begin
                            cyc_addr  <= AW'(UNLOCK_ADDR_A);
                            cyc_wdata <= {{PAD{1'b0}}, CMD_UNLOCK1};
                        end
                        2'd1: begin
                            cyc_addr  <= AW'(UNLOCK_ADDR_B);
                            cyc_wdata <= {{PAD{1'b0}}, CMD_UNLOCK2};
                        end
                        2'd2: begin
                            cyc_addr  <= AW'(UNLOCK_ADDR_A);
                            cyc_wdata <= {{PAD{1'b0}}, CMD_PROGRAM};
                        end
                        default: begin
                            cyc_addr  <= cur_addr;
                            cyc_wdata <= src_data;
                            prog_q    <= src_data;
                        end
                    endcase
                    st <= S_CMD_W;
                end
                S_CMD_W: begin
                    if (cyc_done) begin
                        if (step == 2'd3) begin
                            second_look <= 1'b0;
                            st          <= S_RD;
                        end else begin
                            step <= step + 1'b1;
                            st   <= S_CMD;
                        end
                    end
                end
                S_RD: begin
                    rd_go    <= 1'b1;
                    cyc_addr <= cur_addr;
                    st       <= S_RD_W;
                end
                S_RD_W: begin
                    if (cyc_done) st <= S_EVAL;
                end
                S_EVAL: begin
                    case (verdict)
                        V_PASS: begin
                            if (remain == AW'(1)) begin
                                st <= S_FIN_OK;
                            end else begin
                                cur_addr <= cur_addr + 1'b1;
                                remain   <= remain - 1'b1;
                                step     <= '0;
                                st       <= S_CMD;
                            end
                        end
                        V_RETRY:   st <= S_RD;
                        V_RECHECK: begin
                            second_look <= 1'b1;
                            st          <= S_RD;
                        end
                        default:   st <= S_ABORT;
                    endcase
                end
                S_ABORT: begin
                    wr_go     <= 1'b1;
                    cyc_addr  <= cur_addr;
                    cyc_wdata <= {{PAD{1'b0}}, CMD_READRST};
                    st        <= S_ABORT_W;
                end
                S_ABORT_W: begin
                    if (cyc_done) st <= S_FIN_BAD;
                end
                S_FIN_OK: begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                S_FIN_BAD: begin
                    failed    <= 1'b1;
                    fail_addr <= cur_addr;
                    st        <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R7
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && failed));

    // R7
    fail_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> ((fail_addr - base_q) < cnt_q));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st != S_IDLE) |=> ($stable(base_q) && $stable(cnt_q)));

    // R8
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/nor_prog_ctrl.sv
// NOR flash word programming controller (top). Connects the sequencer,
// the poll judge and the bus cycle engine. Only bits 7 and 5 of read data
// carry meaning during polling; the other read bits are not inspected.
module nor_prog_ctrl
    import nfl_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int WR_PULSE = 3,
    parameter int RD_WAIT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] word_count,
    output logic [AW-1:0] src_idx,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic          done,
    output logic          failed,
    output logic [AW-1:0] fail_addr
);
    logic          wr_go, rd_go, cyc_done;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_wdata;
    logic          poll_b7, poll_b5, second_look, exp_b7;
    verdict_e      verdict;

    nfl_prog_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_addr(base_addr), .word_count(word_count),
        .src_idx(src_idx), .src_data(src_data),
        .wr_go(wr_go), .rd_go(rd_go), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
        .cyc_done(cyc_done), .verdict(verdict),
        .second_look(second_look), .exp_b7(exp_b7),
        .done(done), .failed(failed), .fail_addr(fail_addr)
    );

    nfl_poll_judge u_judge (
        .rd_b7(poll_b7), .rd_b5(poll_b5), .exp_b7(exp_b7),
        .second_look(second_look), .verdict(verdict)
    );

    nfl_bus_engine #(.AW(AW), .DW(DW), .WR_PULSE(WR_PULSE), .RD_WAIT(RD_WAIT)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done),
        .poll_b7(poll_b7), .poll_b5(poll_b5),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

endmodule

// File: tb/nor_prog_ctrl_bench.sv
// Scoreboard bench: a run task pushes expected bus writes into a queue; a
// monitor pops them on each write-enable rising edge. A device model answers
// polling reads per word in one of three modes: normal, fail, or race.
module nor_prog_ctrl_bench;
    localparam int AW  = 18;
    localparam int DW  = 16;
    localparam int WRP = 3;
    localparam int RDW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] word_count = '0;
    logic [AW-1:0] src_idx;
    logic [DW-1:0] src_data;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata;
    logic          fl_ce_n, fl_oe_n, fl_we_n;
    logic          done, failed;
    logic [AW-1:0] fail_addr;

    always #4 clk = ~clk;

    nor_prog_ctrl #(.AW(AW), .DW(DW), .WR_PULSE(WRP), .RD_WAIT(RDW)) u_nor_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .src_idx(src_idx), .src_data(src_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .done(done), .failed(failed), .fail_addr(fail_addr)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Data source stimulus
    int seed = 0;
    function automatic logic [DW-1:0] pat(input logic [AW-1:0] i, input int s);
        return DW'(32'hA5C3 ^ (int'(i) * 32'h1357) ^ s);
    endfunction
    assign src_data = pat(src_idx, seed);

    // Device model state
    logic [DW-1:0] pd = '0;
    int            reads = 0;
    int            rd_total = 0;
    int            prog_off = 0;
    int            fail_off = -1;
    int            race_off = -1;
    logic [AW-1:0] cur_base = '0;
    bit            prev_a0 = 1'b0;

    function automatic int mode_of(input int off);
        if (off == fail_off) return 1;
        if (off == race_off) return 2;
        return 0;
    endfunction

    // Read data: busy pattern has bit 7 inverted, bit 5 as time-limit flag
    always_comb begin
        int b;
        int m;
        logic [DW-1:0] busy0;
        b = prog_off % 3;
        m = mode_of(prog_off);
        busy0 = ~pd & ~DW'(16'h0020);
        if (reads < b)       fl_rdata = busy0;
        else if (reads == b) fl_rdata = (m == 0) ? pd : (busy0 | DW'(16'h0020));
        else                 fl_rdata = (m == 1) ? (busy0 | DW'(16'h0020)) : pd;
    end

    // Scoreboard queues
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];
    string         q_req[$];

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input string r);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_req.push_back(r);
    endtask

    // Monitor: capture each write at write-enable rise and compare
    always @(posedge fl_we_n) begin
        if (rst_n && !fl_ce_n) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R2", "unexpected write addr", longint'(fl_addr), 0);
            end else begin
                logic [AW-1:0] ea;
                logic [DW-1:0] ed;
                string er;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                er = q_req.pop_front();
                check(fl_addr == ea, er, "write addr", longint'(fl_addr), longint'(ea));
                check(fl_wdata == ed, er, "write data", longint'(fl_wdata), longint'(ed));
            end
            if (prev_a0) begin
                pd       = fl_wdata;
                reads    = 0;
                prog_off = int'(fl_addr - cur_base);
            end
            prev_a0 = (fl_addr == AW'(12'h555)) && (fl_wdata == DW'(8'hA0));
        end
    end

    // Device read counter, advanced when output enable returns high
    always @(posedge fl_oe_n) begin
        if (rst_n) begin
            reads++;
            rd_total++;
        end
    end

    // Strobe width, overlap and stability monitor sampled mid-cycle
    int            we_run = 0;
    int            oe_run = 0;
    bit            we_moved = 1'b0;
    logic [AW-1:0] we_a;
    logic [DW-1:0] we_d;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n && !fl_oe_n) check(1'b0, "R4", "WE and OE both low", 0, 1);
            if ((!fl_we_n || !fl_oe_n) && fl_ce_n) check(1'b0, "R3", "strobe without CE", 1, 0);
            if (!fl_we_n) begin
                if (we_run == 0) begin
                    we_a = fl_addr;
                    we_d = fl_wdata;
                    we_moved = 1'b0;
                end else if (fl_addr != we_a || fl_wdata != we_d) begin
                    we_moved = 1'b1;
                end
                we_run++;
            end else if (we_run != 0) begin
                check(we_run == WRP, "R3", "WE low width", we_run, WRP);
                check(!we_moved, "R3", "addr/data moved under WE", we_moved, 0);
                we_run = 0;
            end
            if (!fl_oe_n) begin
                oe_run++;
            end else if (oe_run != 0) begin
                check(oe_run == RDW, "R4", "OE low width", oe_run, RDW);
                oe_run = 0;
            end
        end
    end

    // One programming run with expected traffic pushed up front
    task automatic run(input logic [AW-1:0] base, input int cnt, input int f_off,
                       input int r_off, input int s, input bit extra_start,
                       input string rtag);
        int  exp_rd;
        bit  exp_fail;
        logic [AW-1:0] exp_fa;
        int  k;
        bit  got_done, got_fail;
        logic [AW-1:0] got_fa;
        seed     = s;
        fail_off = f_off;
        race_off = r_off;
        cur_base = base;
        exp_rd   = 0;
        exp_fail = 1'b0;
        exp_fa   = '0;
        for (int i = 0; i < cnt; i++) begin
            int m;
            m = mode_of(i);
            push(AW'(12'h555), DW'(8'hAA), "R2");
            push(AW'(12'h2AA), DW'(8'h55), "R2");
            push(AW'(12'h555), DW'(8'hA0), "R2");
            push(base + AW'(i), pat(AW'(i), s), "R8");
            exp_rd += (i % 3) + ((m == 0) ? 1 : 2);
            if (m == 1) begin
                push(base + AW'(i), DW'(8'hF0), "R7");
                exp_fail = 1'b1;
                exp_fa   = base + AW'(i);
                break;
            end
        end
        @(negedge clk);
        rd_total   = 0;
        base_addr  = base;
        word_count = AW'(cnt);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (12) @(negedge clk);
            base_addr  = AW'(7);
            word_count = AW'(1);
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got_done = 1'b0;
        got_fail = 1'b0;
        got_fa   = '0;
        k = 0;
        while (k < 5000 && !got_done && !got_fail) begin
            @(negedge clk);
            got_done = done;
            got_fail = failed;
            got_fa   = fail_addr;
            k++;
        end
        check(got_done == !exp_fail, exp_fail ? "R7" : "R8", "done pulse", got_done, !exp_fail);
        check(got_fail == exp_fail, "R7", "failed pulse", got_fail, exp_fail);
        if (exp_fail) check(got_fa == exp_fa, "R7", "fail_addr", longint'(got_fa), longint'(exp_fa));
        @(negedge clk);
        check(!done && !failed, "R8", "result pulse one clock", {done, failed}, 0);
        repeat (20) @(negedge clk);
        check(q_addr.size() == 0, rtag, "writes left unseen", q_addr.size(), 0);
        check(rd_total == exp_rd, rtag, "polling reads", rd_total, exp_rd);
        q_addr.delete();
        q_data.delete();
        q_req.delete();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(fl_ce_n === 1'b1, "R1", "ce_n in reset", fl_ce_n, 1);
        check(fl_we_n === 1'b1, "R1", "we_n in reset", fl_we_n, 1);
        check(fl_oe_n === 1'b1, "R1", "oe_n in reset", fl_oe_n, 1);
        check(done === 1'b0 && failed === 1'b0, "R1", "result pulses in reset", {done, failed}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5, R8: plain multi-word run with varying busy lengths
        run(AW'(18'h00100), 3, -1, -1, 32'h0011, 1'b0, "R5");
        // R6: time-limit flag raised on the completing read, re-read passes
        run(AW'(18'h02000), 5, -1, 2, 32'h5A5A, 1'b0, "R6");
        // R7: second word fails; abort write and stop
        run(AW'(18'h00040), 4, 1, -1, 32'h0F0F, 1'b0, "R7");
        // R7: first word fails with no busy reads before the flag
        run(AW'(18'h3FF00), 2, 0, -1, 32'h1234, 1'b0, "R7");
        // R9: zero-length request
        run(AW'(18'h00200), 0, -1, -1, 32'h0000, 1'b0, "R9");
        // R10: start pulse during an active run is ignored
        run(AW'(18'h00500), 2, -1, -1, 32'h7777, 1'b1, "R10");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule